// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address, given as a segment number and a word offset, into a physical memory address. It holds a small table of segment descriptors in flops. Each descriptor has four fields: a presence flag, a master-copy flag, a segment length in words and a base address. A lookup reads the descriptor for the requested segment and checks two conditions. The segment must be resident in main memory, and the offset must lie inside the segment. When both hold, the result is the base plus the offset.

A host loads and updates descriptors through a one-entry-per-cycle write port. Each lookup gives exactly one outcome one cycle after the request. The outcome is one of three:
- a valid physical address, reported together with the master-copy flag;
- a segment-absent fault;
- a length-violation fault.

A non-resident descriptor's base refers to backing store, so a lookup on it never produces an address.

Top module: `seg_xlate`

## Requirements
- R1: After reset all result outputs are 0, and every descriptor reads as absent, so a lookup of any segment (for example segment 0 or 15) raises the segment-absent fault.
- R2: A request accepted at a clock edge produces its outcome in the cycle after that edge. In that cycle exactly one of `out_valid`, `out_absent_fault` and `out_length_fault` is 1. In a cycle that follows no request, all three are 0.
- R3: For a present descriptor with offset < length, `out_addr` equals (base + offset) truncated to 20 bits, so a sum past 0xFFFFF wraps around.
- R4: `out_master` carries the descriptor's master-copy flag when `out_valid` is 1, and is 0 otherwise.
- R5: For a present descriptor with offset >= length, `out_length_fault` is 1, `out_valid` is 0 and `out_addr` is 0.
- R6: For a descriptor with presence 0, `out_absent_fault` is 1, `out_valid` is 0 and `out_addr` is 0. This holds even when the offset is also out of range; in that case `out_length_fault` stays 0.
- R7: A descriptor write is seen by a lookup in a later cycle. A lookup in the same cycle as a write to the same entry returns the entry's old contents.
- R8: A write to one entry leaves the other entries unchanged.
- R9: For a present descriptor, offset = length-1 translates and offset = length faults. A length of 0 makes every offset fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_seg | input | 4 | Segment number of the lookup |
| req_disp | input | 20 | Word offset within the segment |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | 4 | Entry to write |
| wr_present | input | 1 | Presence flag to store |
| wr_master | input | 1 | Master-copy flag to store |
| wr_len | input | 20 | Segment length in words |
| wr_base | input | 20 | Segment base address |
| out_valid | output | 1 | Translation succeeded |
| out_addr | output | 20 | Physical address, 0 when not valid |
| out_master | output | 1 | Master-copy flag of the translated segment |
| out_absent_fault | output | 1 | Segment not resident |
| out_length_fault | output | 1 | Offset outside segment |

## Verification
The bench probes the bounds check at offset = length-1 and at offset = length, and also with a zero length. An off-by-one comparison would pass the last illegal word or reject the last legal one. It looks up an absent segment whose offset is also too large. A design with the wrong fault priority would raise the length fault there, or raise both faults at once. It also drives a base near the top of the address space to catch an adder that saturates or carries into a wider result. Finally, it issues a write and a lookup of the same entry in one cycle, which exposes a table that forwards the new contents instead of returning the old ones.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_ABSENT = 2'd1,
    XF_LENGTH = 2'd2
  } xlate_fault_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_present,
  input  logic              wr_master,
  input  logic [OFF_W-1:0]  wr_len,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic              rd_present,
  output logic              rd_master,
  output logic [OFF_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] rd_base
);
  localparam int ENTRIES = 2 ** SEG_W;

  logic              pres_q [ENTRIES];
  logic              mast_q [ENTRIES];
  logic [OFF_W-1:0]  len_q  [ENTRIES];
  logic [ADDR_W-1:0] base_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        pres_q[i] <= 1'b0;
        mast_q[i] <= 1'b0;
        len_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else if (wr_en) begin
      pres_q[wr_seg] <= wr_present;
      mast_q[wr_seg] <= wr_master;
      len_q[wr_seg]  <= wr_len;
      base_q[wr_seg] <= wr_base;
    end
  end

  // Read port samples the flops, so a same-cycle write is not visible yet.
  assign rd_present = pres_q[rd_seg];
  assign rd_master  = mast_q[rd_seg];
  assign rd_len     = len_q[rd_seg];
  assign rd_base    = base_q[rd_seg];
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 20
) (
  input  logic              present,
  input  logic [OFF_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  output xlate_fault_e      fault,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] eff_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [OFF_W-1:0] d);
    logic [ADDR_W:0] s;
    s = {1'b0, b} + (ADDR_W + 1)'(d);
    return s[ADDR_W-1:0];
  endfunction

  function automatic logic inside_seg(input logic [OFF_W-1:0] d,
                                      input logic [OFF_W-1:0] l);
    return d < l;
  endfunction

  always_comb begin
    if (!present)                 fault = XF_ABSENT;
    else if (!inside_seg(disp, len)) fault = XF_LENGTH;
    else                          fault = XF_NONE;
  end

  assign addr = eff_addr(base, disp);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_disp,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_present,
  input  logic              wr_master,
  input  logic [OFF_W-1:0]  wr_len,
  input  logic [ADDR_W-1:0] wr_base,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_master,
  output logic              out_absent_fault,
  output logic              out_length_fault
);
  logic              rd_present;
  logic              rd_master;
  logic [OFF_W-1:0]  rd_len;
  logic [ADDR_W-1:0] rd_base;
  xlate_fault_e      calc_fault;
  logic [ADDR_W-1:0] calc_addr;
  logic              hit_ok;

  seg_desc_table #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present),
    .wr_master(wr_master), .wr_len(wr_len), .wr_base(wr_base),
    .rd_seg(req_seg), .rd_present(rd_present), .rd_master(rd_master),
    .rd_len(rd_len), .rd_base(rd_base)
  );

  seg_xlate_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_calc (
    .present(rd_present), .len(rd_len), .base(rd_base), .disp(req_disp),
    .fault(calc_fault), .addr(calc_addr)
  );

  assign hit_ok = req_valid && (calc_fault == XF_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      out_addr         <= '0;
      out_master       <= 1'b0;
      out_absent_fault <= 1'b0;
      out_length_fault <= 1'b0;
    end else begin
      out_valid        <= hit_ok;
      out_addr         <= hit_ok ? calc_addr : '0;
      out_master       <= hit_ok && rd_master;
      out_absent_fault <= req_valid && (calc_fault == XF_ABSENT);
      out_length_fault <= req_valid && (calc_fault == XF_LENGTH);
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OFF_W-1:0]  req_disp,
  input logic              rd_present,
  input logic [OFF_W-1:0]  rd_len,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_master,
  input logic              out_absent_fault,
  input logic              out_length_fault
);
  // R2
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({out_valid, out_absent_fault, out_length_fault}) == 1);
  // R2
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(out_valid || out_absent_fault || out_length_fault));
  // R4, R5
  a_r4_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_addr == '0) && !out_master);
  // R6
  a_r6_absent_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rd_present) |=> out_absent_fault && !out_length_fault);
  // R5
  a_r5_length_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_present && (req_disp >= rd_len)) |=> out_length_fault && !out_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_disp(req_disp),
  .rd_present(rd_present), .rd_len(rd_len), .out_valid(out_valid),
  .out_addr(out_addr), .out_master(out_master),
  .out_absent_fault(out_absent_fault), .out_length_fault(out_length_fault)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [19:0] req_disp = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_seg = '0;
  logic        wr_present = 1'b0;
  logic        wr_master = 1'b0;
  logic [19:0] wr_len = '0;
  logic [19:0] wr_base = '0;
  logic        out_valid;
  logic [19:0] out_addr;
  logic        out_master;
  logic        out_absent_fault;
  logic        out_length_fault;

  int checks = 0;
  int fails = 0;

  seg_xlate uut (.*);

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Packs {valid, absent, length, master} and address for one comparison.
  task automatic expect_out(input string tag, input logic v, input logic ab,
                            input logic ln, input logic m, input logic [19:0] a);
    check(tag, {out_valid, out_absent_fault, out_length_fault, out_master, out_addr},
          {v, ab, ln, m, a});
  endtask

  task automatic write_desc(input logic [3:0] s, input logic p, input logic m,
                            input logic [19:0] l, input logic [19:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = s; wr_present = p; wr_master = m; wr_len = l; wr_base = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [3:0] s, input logic [19:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_disp = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R1 reset outputs", 0, 0, 0, 0, 20'h0);
    lookup(4'd0, 20'h0);
    expect_out("R1 seg0 absent after reset", 0, 1, 0, 0, 20'h0);
    lookup(4'd15, 20'h5);
    expect_out("R1 seg15 absent after reset", 0, 1, 0, 0, 20'h0);
  endtask

  task automatic t_basic;
    write_desc(4'd3, 1, 1, 20'h00100, 20'h01000);
    write_desc(4'd5, 1, 0, 20'h00800, 20'h23450);
    lookup(4'd3, 20'h00010);
    expect_out("R3 R4 seg3 translate master", 1, 0, 0, 1, 20'h01010);
    lookup(4'd5, 20'h00123);
    expect_out("R3 R4 seg5 translate non-master", 1, 0, 0, 0, 20'h23573);
  endtask

  task automatic t_bounds;
    lookup(4'd3, 20'h000FF);
    expect_out("R9 last legal word", 1, 0, 0, 1, 20'h010FF);
    lookup(4'd3, 20'h00100);
    expect_out("R9 R5 first illegal word", 0, 0, 1, 0, 20'h0);
    lookup(4'd3, 20'hFFFFF);
    expect_out("R5 far out of range", 0, 0, 1, 0, 20'h0);
    write_desc(4'd6, 1, 1, 20'h0, 20'h00400);
    lookup(4'd6, 20'h0);
    expect_out("R9 zero length", 0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_absent;
    write_desc(4'd7, 0, 1, 20'h00200, 20'h30000);
    lookup(4'd7, 20'h00001);
    expect_out("R6 absent in range", 0, 1, 0, 0, 20'h0);
    lookup(4'd7, 20'h00300);
    expect_out("R6 absent wins over length", 0, 1, 0, 0, 20'h0);
  endtask

  task automatic t_wrap;
    write_desc(4'd9, 1, 0, 20'hFFFFF, 20'hFFFF0);
    lookup(4'd9, 20'h00020);
    expect_out("R3 wrap at 20 bits", 1, 0, 0, 0, 20'h00010);
  endtask

  task automatic t_idle;
    lookup(4'd3, 20'h1);
    expect_out("R2 result one cycle after request", 1, 0, 0, 1, 20'h01001);
    @(negedge clk);
    expect_out("R2 idle cycle quiet", 0, 0, 0, 0, 20'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 4'd3; wr_present = 1'b1; wr_master = 1'b0;
    wr_len = 20'h00040; wr_base = 20'h50000;
    req_valid = 1'b1; req_seg = 4'd3; req_disp = 20'h00080;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_out("R7 same-cycle lookup sees old entry", 1, 0, 0, 1, 20'h01080);
    lookup(4'd3, 20'h00020);
    expect_out("R7 later lookup sees new entry", 1, 0, 0, 0, 20'h50020);
  endtask

  task automatic t_isolation;
    write_desc(4'd4, 0, 0, 20'h0, 20'h0);
    lookup(4'd5, 20'h00123);
    expect_out("R8 neighbour entry unchanged", 1, 0, 0, 0, 20'h23573);
    lookup(4'd3, 20'h00020);
    expect_out("R8 other entry unchanged", 1, 0, 0, 0, 20'h50020);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_absent();
    t_wrap();
    t_idle();
    t_same_cycle();
    t_isolation();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule